// File: doc/BRIEF.md
# Sub-channel Peak Interpolating Frequency Estimator

This block estimates the carrier offset of a received burst from the outputs of a bank of parallel correlators. Each correlator covers one sub-channel, and the sub-channel centres are 100 kHz apart, starting at 500 kHz. Each correlator reports a 24-bit peak correlation value and a flag that says whether the peak is trustworthy. When the correlation stage pulses `start`, the block takes a copy of all values and flags. It zeroes the untrusted ones and picks the strongest sub-channel. It then fits a parabola through that peak and its two neighbours to find where the true maximum lies between channel centres.

The fitted offset is quantized to eighths of a channel spacing as a 4-bit sign-magnitude code. The block then outputs:
- the estimated frequency, in half-kHz units;
- a frequency control word that snaps the estimate to the 25 kHz grid of the local oscillator synthesizer, counted in 25 kHz units.

A one-cycle `done` pulse marks fresh results. The quotient of the fit comes from a sequential restoring divider.

The controller has five states:
- IDLE waits for `start`.
- SEARCH registers the argmax and the neighbour values. It goes back to IDLE if no flag was set.
- PREP forms the fit terms. It goes to DIVIDE when the denominator is non-zero, and straight to FINISH when it is zero.
- DIVIDE waits for the divider to finish.
- FINISH writes the outputs, pulses `done` and returns to IDLE.

Top module: `subband_freq_est`

## Requirements
- R1: While and after reset, `done` is 0 and `peak_idx`, `frac_code`, `freq_hkhz` and `fcw` are 0.
- R2: A sub-channel whose `peak_valid` bit is 0 takes part in the search and the fit with value 0, whatever its `peak_vals` field holds. Sub-channel i occupies `peak_vals[24*i+23:24*i]`.
- R3: `peak_idx` is the index of the largest masked value. When several sub-channels tie, the lowest index wins.
- R4: The fraction a = (y[n+1] − y[n−1]) / (2·(2·y[n] − y[n−1] − y[n+1])) is rounded to the nearest 1/8, with halves rounded away from zero, and is limited to a magnitude of 7/8. `frac_code[3]` is the sign (1 = negative) and `frac_code[2:0]` the magnitude in eighths. A zero magnitude always has sign 0.
- R5: At index 0 or 10 the missing neighbour counts as 0. When the denominator is 0, the fraction is 0.
- R6: `freq_hkhz` = 2·(500 + 100·(n + a)), i.e. the estimate in units of 0.5 kHz.
- R7: `fcw` is the estimate rounded to the nearest multiple of 25 kHz, expressed in 25 kHz units, with exact halves rounded up.
- R8: With `start` sampled high on clock edge k, `done` is high for exactly the one cycle after edge k+32 when the denominator is non-zero, and after edge k+3 when it is zero.
- R9: When no `peak_valid` bit is set, `done` stays low, every output keeps its previous value, and the next `start` is accepted two cycles after the ignored one.
- R10: `start`, and any change of `peak_vals` or `peak_valid`, has no effect while an estimate is in progress. Results depend only on the inputs sampled at the accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an estimate using the present inputs |
| peak_vals | input | 264 | Eleven unsigned 24-bit peak values, sub-channel 0 in the low bits |
| peak_valid | input | 11 | Per-sub-channel valid flags |
| done | output | 1 | One-cycle pulse: results updated |
| peak_idx | output | 4 | Integer sub-channel index n |
| frac_code | output | 4 | Sign-magnitude fraction in eighths |
| freq_hkhz | output | 16 | Estimated frequency, 0.5 kHz units |
| fcw | output | 12 | Control word, 25 kHz units |

## Verification
The bench builds the block with its default parameters: eleven sub-channels of 24-bit values, a 3-bit fraction magnitude, a 500 kHz start, a 100 kHz spacing and a 25 kHz grid. These values place a peak on both end channels and put full-scale values through the fit, so the widest numerator and the full 28-step divider run are reached. The odd fraction codes that they produce land exactly halfway between grid points, which exercises the half-up rounding of the control word. A cycle-accurate behavioural model predicts `done` and every output on each clock. It does so through masked-zero searches, ties, flat peaks, runs with no valid flag, and starts and input changes during a run.

// File: rtl/sfe_pkg.sv
`timescale 1ns/1ps
package sfe_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEARCH,
        ST_PREP,
        ST_DIVIDE,
        ST_FINISH
    } sfe_state_t;
endpackage

// File: rtl/sfe_peak_pick.sv
`timescale 1ns/1ps
// Masks untrusted sub-channels to zero, finds the first maximum and
// returns it with its neighbours (zero beyond either end).
module sfe_peak_pick #(
    parameter int NUM_CH = 11,
    parameter int VAL_W  = 24,
    parameter int IDX_W  = 4
) (
    input  logic [NUM_CH*VAL_W-1:0] vals,
    input  logic [NUM_CH-1:0]       valid,
    output logic [IDX_W-1:0]        best_idx,
    output logic [VAL_W-1:0]        left_val,
    output logic [VAL_W-1:0]        ctr_val,
    output logic [VAL_W-1:0]        right_val,
    output logic                    any_valid
);
    // padded view: slot 0 and slot NUM_CH+1 are permanent zeros
    logic [VAL_W-1:0] padded [NUM_CH+2];

    assign padded[0]        = '0;
    assign padded[NUM_CH+1] = '0;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_mask
        assign padded[g+1] = valid[g] ? vals[g*VAL_W +: VAL_W] : '0;
    end

    assign any_valid = |valid;

    logic [VAL_W-1:0] best_val;

    always_comb begin
        best_idx = '0;
        best_val = padded[1];
        for (int i = 1; i < NUM_CH; i++) begin
            if (padded[i+1] > best_val) begin
                best_val = padded[i+1];
                best_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        left_val  = '0;
        ctr_val   = '0;
        right_val = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (IDX_W'(i) == best_idx) begin
                left_val  = padded[i];
                ctr_val   = padded[i+1];
                right_val = padded[i+2];
            end
        end
    end
endmodule

// File: rtl/sfe_frac_div.sv
`timescale 1ns/1ps
// Restoring divider, one quotient bit per clock, NUM_W steps per run.
module sfe_frac_div #(
    parameter int NUM_W = 28,
    parameter int DEN_W = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NUM_W-1:0] numer,
    input  logic [DEN_W-1:0] denom,
    output logic [NUM_W-1:0] quot,
    output logic             finished
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [CNT_W-1:0] steps_left;
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [DEN_W:0]   rem_shift;
    logic             fits;

    assign rem_shift = {rem_q, quot[NUM_W-1]};
    assign fits      = rem_shift >= {1'b0, den_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            steps_left <= '0;
            rem_q      <= '0;
            den_q      <= '0;
            quot       <= '0;
            finished   <= 1'b0;
        end else if (load) begin
            steps_left <= CNT_W'(NUM_W);
            rem_q      <= '0;
            den_q      <= denom;
            quot       <= numer;
            finished   <= 1'b0;
        end else if (steps_left != '0) begin
            steps_left <= steps_left - 1'b1;
            rem_q      <= fits ? DEN_W'(rem_shift - {1'b0, den_q}) : rem_shift[DEN_W-1:0];
            quot       <= {quot[NUM_W-2:0], fits};
            finished   <= (steps_left == CNT_W'(1));
        end else begin
            finished   <= 1'b0;
        end
    end
endmodule

// File: rtl/subband_freq_est.sv
`timescale 1ns/1ps
module subband_freq_est
    import sfe_pkg::*;
#(
    parameter int NUM_CH   = 11,
    parameter int VAL_W    = 24,
    parameter int FRAC_W   = 4,
    parameter int BASE_KHZ = 500,
    parameter int STEP_KHZ = 100,
    parameter int GRID_KHZ = 25,
    parameter int FREQ_W   = 16,
    parameter int FCW_W    = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [NUM_CH*VAL_W-1:0] peak_vals,
    input  logic [NUM_CH-1:0]       peak_valid,
    output logic                    done,
    output logic [$clog2(NUM_CH)-1:0] peak_idx,
    output logic [FRAC_W-1:0]       frac_code,
    output logic [FREQ_W-1:0]       freq_hkhz,
    output logic [FCW_W-1:0]        fcw
);
    localparam int IDX_W   = $clog2(NUM_CH);
    localparam int MAG_W   = FRAC_W - 1;
    localparam int Q_W     = VAL_W + 2;
    localparam int NUM_W   = VAL_W + 1 + MAG_W;
    localparam int DEN_W   = Q_W + 1;
    localparam int UNIT_HK = (2 * STEP_KHZ) >> MAG_W;      // half-kHz per eighth step
    localparam int BASE_E  = (2 * BASE_KHZ) / UNIT_HK;     // start frequency in eighth steps
    localparam int GRID_E  = (2 * GRID_KHZ) / UNIT_HK;     // grid pitch in eighth steps
    localparam int G_SHIFT = $clog2(GRID_E);
    localparam int E_W     = FREQ_W;

    sfe_state_t state_q, state_d;

    // ---------------- snapshot and search ----------------
    logic [NUM_CH*VAL_W-1:0] snap_vals;
    logic [NUM_CH-1:0]       snap_valid;
    logic [IDX_W-1:0]        pick_idx;
    logic [VAL_W-1:0]        pick_l, pick_c, pick_r;
    logic                    pick_any;

    sfe_peak_pick #(.NUM_CH(NUM_CH), .VAL_W(VAL_W), .IDX_W(IDX_W)) u_pick (
        .vals      (snap_vals),
        .valid     (snap_valid),
        .best_idx  (pick_idx),
        .left_val  (pick_l),
        .ctr_val   (pick_c),
        .right_val (pick_r),
        .any_valid (pick_any)
    );

    logic [IDX_W-1:0] idx_r;
    logic [VAL_W-1:0] yl_r, yc_r, yr_r;
    logic [MAG_W-1:0] mag_r;

    // ---------------- fit terms ----------------
    logic [VAL_W:0]   diff_lr;
    logic             p_neg;
    logic [VAL_W:0]   abs_p;
    logic [Q_W-1:0]   q_full;
    logic [NUM_W-1:0] div_num;
    logic [DEN_W-1:0] div_den;
    logic             div_load;
    logic [NUM_W-1:0] div_quot;
    logic             div_fin;
    logic [MAG_W-1:0] mag_clamped;

    assign diff_lr = {1'b0, yr_r} - {1'b0, yl_r};
    assign p_neg   = diff_lr[VAL_W];
    assign abs_p   = p_neg ? (~diff_lr + 1'b1) : diff_lr;
    assign q_full  = {1'b0, yc_r, 1'b0} - {2'b00, yl_r} - {2'b00, yr_r};
    assign div_num = {abs_p, {MAG_W{1'b0}}} + NUM_W'(q_full);
    assign div_den = {q_full, 1'b0};
    assign div_load = (state_q == ST_PREP) && (q_full != '0);

    sfe_frac_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (div_load),
        .numer    (div_num),
        .denom    (div_den),
        .quot     (div_quot),
        .finished (div_fin)
    );

    assign mag_clamped = (|div_quot[NUM_W-1:MAG_W]) ? {MAG_W{1'b1}} : div_quot[MAG_W-1:0];

    // ---------------- result arithmetic ----------------
    logic             frac_neg;
    logic [E_W-1:0]   e_base, e_val;

    assign frac_neg = p_neg && (mag_r != '0);
    assign e_base   = E_W'(BASE_E) + (E_W'(idx_r) << MAG_W);
    assign e_val    = frac_neg ? (e_base - E_W'(mag_r)) : (e_base + E_W'(mag_r));

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SEARCH;
            ST_SEARCH: state_d = pick_any ? ST_PREP : ST_IDLE;
            ST_PREP:   state_d = (q_full != '0) ? ST_DIVIDE : ST_FINISH;
            ST_DIVIDE: if (div_fin) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_vals  <= '0;
            snap_valid <= '0;
            idx_r      <= '0;
            yl_r       <= '0;
            yc_r       <= '0;
            yr_r       <= '0;
            mag_r      <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                snap_vals  <= peak_vals;
                snap_valid <= peak_valid;
            end
            if (state_q == ST_SEARCH && pick_any) begin
                idx_r <= pick_idx;
                yl_r  <= pick_l;
                yc_r  <= pick_c;
                yr_r  <= pick_r;
            end
            if (state_q == ST_PREP)                mag_r <= '0;
            if (state_q == ST_DIVIDE && div_fin)   mag_r <= mag_clamped;
        end
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done      <= 1'b0;
            peak_idx  <= '0;
            frac_code <= '0;
            freq_hkhz <= '0;
            fcw       <= '0;
        end else if (state_q == ST_FINISH) begin
            done      <= 1'b1;
            peak_idx  <= idx_r;
            frac_code <= {frac_neg, mag_r};
            freq_hkhz <= FREQ_W'(e_val * UNIT_HK);
            fcw       <= FCW_W'((e_val + E_W'(GRID_E / 2)) >> G_SHIFT);
        end else begin
            done      <= 1'b0;
        end
    end
endmodule

// File: rtl/subband_freq_est_chk.sv
`timescale 1ns/1ps
module subband_freq_est_chk
    import sfe_pkg::*;
#(
    parameter int NUM_CH   = 11,
    parameter int FRAC_W   = 4,
    parameter int GRID_KHZ = 25,
    parameter int FREQ_W   = 16,
    parameter int FCW_W    = 12
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      done,
    input logic [$clog2(NUM_CH)-1:0] peak_idx,
    input logic [FRAC_W-1:0]         frac_code,
    input logic [FREQ_W-1:0]         freq_hkhz,
    input logic [FCW_W-1:0]          fcw,
    input sfe_state_t                state
);
    localparam int GRID_HK = 2 * GRID_KHZ;

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(state) == ST_FINISH);

    assert_outputs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(peak_idx) && $stable(frac_code) && $stable(freq_hkhz) && $stable(fcw)));

    assert_no_negative_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(frac_code[FRAC_W-1] && frac_code[FRAC_W-2:0] == '0));

    assert_idx_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> int'(peak_idx) < NUM_CH);

    assert_grid_snap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((int'(freq_hkhz) - int'(fcw) * GRID_HK) >= -(GRID_HK / 2)
              && (int'(freq_hkhz) - int'(fcw) * GRID_HK) <   (GRID_HK / 2)));

    assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (state != ST_SEARCH));
endmodule

bind subband_freq_est subband_freq_est_chk #(
    .NUM_CH(NUM_CH), .FRAC_W(FRAC_W), .GRID_KHZ(GRID_KHZ), .FREQ_W(FREQ_W), .FCW_W(FCW_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .peak_idx(peak_idx), .frac_code(frac_code),
    .freq_hkhz(freq_hkhz), .fcw(fcw), .state(state_q)
);

// File: tb/subband_freq_est_bench.sv
`timescale 1ns/1ps
module subband_freq_est_bench;
    localparam int NUM_CH = 11;
    localparam int VAL_W  = 24;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    start = 1'b0;
    logic [NUM_CH*VAL_W-1:0] peak_vals = '0;
    logic [NUM_CH-1:0]       peak_valid = '0;
    logic                    done;
    logic [3:0]              peak_idx;
    logic [3:0]              frac_code;
    logic [15:0]             freq_hkhz;
    logic [11:0]             fcw;

    subband_freq_est u_subband_freq_est (
        .clk(clk), .rst_n(rst_n), .start(start), .peak_vals(peak_vals),
        .peak_valid(peak_valid), .done(done), .peak_idx(peak_idx),
        .frac_code(frac_code), .freq_hkhz(freq_hkhz), .fcw(fcw)
    );

    always #2.5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    longint cv[NUM_CH];
    bit     cb[NUM_CH];
    // held (currently expected) outputs and pending prediction
    longint h_idx = 0, h_frac = 0, h_freq = 0, h_fcw = 0;
    longint p_idx, p_frac, p_freq, p_fcw;
    int     p_lat;
    bit     p_any;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare_held(input string req);
        check(req, "peak_idx",  longint'(peak_idx),  h_idx);
        check(req, "frac_code", longint'(frac_code), h_frac);
        check(req, "freq_hkhz", longint'(freq_hkhz), h_freq);
        check(req, "fcw",       longint'(fcw),       h_fcw);
    endtask

    task automatic clear_case();
        for (int i = 0; i < NUM_CH; i++) begin
            cv[i] = 0;
            cb[i] = 1'b1;
        end
    endtask

    // behavioural prediction from the requirements
    task automatic predict();
        longint m[NUM_CH+2];
        longint yl, yc, yr, p, q, mag, e;
        int n;
        bit neg;
        m[0] = 0;
        m[NUM_CH+1] = 0;
        p_any = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            m[i+1] = cb[i] ? cv[i] : 0;
            if (cb[i]) p_any = 1'b1;
        end
        n = 0;
        for (int i = 1; i < NUM_CH; i++) if (m[i+1] > m[n+1]) n = i;
        yl = m[n]; yc = m[n+1]; yr = m[n+2];
        p = yr - yl;
        q = 2 * yc - yl - yr;
        if (q == 0) begin
            mag = 0; p_lat = 3;
        end else begin
            mag = (8 * (p < 0 ? -p : p) + q) / (2 * q);
            if (mag > 7) mag = 7;
            p_lat = 32;
        end
        neg = (p < 0) && (mag != 0);
        e = 40 + 8 * n + (neg ? -mag : mag);
        p_idx  = n;
        p_frac = (neg ? 8 : 0) + mag;
        p_freq = e * 25;
        p_fcw  = (e + 1) / 2;
    endtask

    task automatic run_case(input string req, input bit busy_poke);
        int lim;
        for (int i = 0; i < NUM_CH; i++) begin
            peak_vals[i*VAL_W +: VAL_W] = cv[i][VAL_W-1:0];
            peak_valid[i] = cb[i];
        end
        predict();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lim = p_any ? p_lat + 3 : 6;
        for (int j = 1; j <= lim; j++) begin
            if (p_any && j == p_lat + 1) begin
                check("R8", "done at expected cycle", longint'(done), 1);
                h_idx = p_idx; h_frac = p_frac; h_freq = p_freq; h_fcw = p_fcw;
            end else begin
                check(p_any ? "R8" : "R9", "done low", longint'(done), 0);
            end
            compare_held(req);
            if (busy_poke && j == 5) begin
                // R10: start and altered inputs while busy
                peak_vals  = ~peak_vals;
                peak_valid = ~peak_valid;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired, run hung");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "done in reset", longint'(done), 0);
        compare_held("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "done after reset", longint'(done), 0);
        compare_held("R1");

        // R4: interior peak, positive fraction
        clear_case();
        for (int i = 0; i < NUM_CH; i++) cv[i] = 100;
        cv[4] = 1000; cv[5] = 2000; cv[6] = 1500;
        run_case("R4", 1'b0);

        // R2: a larger value on an invalid sub-channel is masked
        clear_case();
        for (int i = 0; i < NUM_CH; i++) cv[i] = 10;
        cv[3] = 900000; cb[3] = 1'b0;
        cv[7] = 3000; cv[8] = 5000; cv[9] = 4500;
        run_case("R2", 1'b0);

        // R3: tie resolves to the lowest index
        clear_case();
        cv[1] = 1000; cv[2] = 7000; cv[3] = 6000;
        cv[6] = 500;  cv[7] = 7000; cv[8] = 200;
        run_case("R3", 1'b0);

        // R5: peak on sub-channel 0, left neighbour is zero
        clear_case();
        cv[0] = 50000; cv[1] = 20000;
        run_case("R5", 1'b0);

        // R5: peak on sub-channel 10 with full-scale values, negative fraction
        clear_case();
        cv[10] = 16777215; cv[9] = 16777214;
        run_case("R5", 1'b0);

        // R5: zero denominator, short latency
        clear_case();
        run_case("R5", 1'b0);

        // R6/R7: negative odd fraction, control word rounds half up
        clear_case();
        cv[5] = 8000; cv[6] = 9000; cv[7] = 2000;
        run_case("R7", 1'b0);

        // R4: fraction exactly half an eighth rounds away from zero
        clear_case();
        cv[2] = 100; cv[3] = 109; cv[4] = 102;
        run_case("R6", 1'b0);

        // R10: start and input changes during a run are ignored
        clear_case();
        cv[7] = 40000; cv[8] = 90000; cv[9] = 85000; cb[2] = 1'b0;
        run_case("R10", 1'b1);

        // R9: nothing valid: no done, outputs held
        clear_case();
        for (int i = 0; i < NUM_CH; i++) begin
            cv[i] = 1234 + i;
            cb[i] = 1'b0;
        end
        run_case("R9", 1'b0);

        // R9: block still accepts the next start
        clear_case();
        cv[1] = 300; cv[2] = 900; cv[3] = 100;
        run_case("R9", 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule